// File: doc/BRIEF.md
# Manchester Frame Receiver

This block takes the raw, unsynchronized data line of a radio receiver and recovers bytes from Manchester-coded frames. Each frame opens with a run of logic-one bits that sets the bit timing, followed by a marker symbol that breaks the coding rules. Payload bits follow. A second marker, the opposite violation, closes the frame, so a frame may carry any number of bytes and needs no length field. Since the radio does no decoding, the block does it all: it synchronizes the line, oversamples it, realigns its half-bit timer on every transition, finds the opening marker, and assembles the bytes.

Decoded bytes leave on a valid/ready stream. The stream has one holding register. A byte stays on `out_data` with `out_valid` high until `out_ready` is seen high at a clock edge. If a new byte completes while the held byte is still waiting and is not taken on that edge, the new byte is dropped. The block never stalls the line, because the radio cannot be paused. A one-cycle `frame_end` pulse reports the closing marker. A separate `chan_busy` level tells a local transmitter that the air is in use, so that it can hold off and avoid a collision.

Top module: `manchester_rx`

## Requirements
- R1: While reset is held and on release, `out_valid`, `frame_end` and `chan_busy` are all low.
- R2: A half-bit pair of high-then-low decodes as 1 and low-then-high decodes as 0. Payload bits fill a byte least-significant bit first, and the byte is offered on `out_data` once its eighth bit is decoded.
- R3: Decoding begins only after `PRE_BITS` (default 4) consecutive 1 bits immediately followed by a full bit period held high. A shorter run of ones, or ones with no high marker, yields no bytes.
- R4: A full bit period held low during payload ends the frame with exactly one single-cycle `frame_end` pulse. This pulse never falls in a cycle where a new byte is offered. Bits of an unfinished byte are discarded, and frames of zero or more bytes are accepted.
- R5: A full bit period held high during payload ends the frame silently, with no `frame_end`. The symbols after it are ignored until a new preamble and opening marker arrive.
- R6: With `out_valid` high and `out_ready` low, `out_valid` and `out_data` stay unchanged. A byte that completes while the register is full and not taken is lost. A byte that completes on the same edge the held byte is taken is loaded.
- R7: `chan_busy` rises when two line transitions fall at most two bit periods (4*OVS samples) apart. Transitions spaced farther apart leave it low.
- R8: `chan_busy` falls exactly `QUIET_SAMPLES` sample ticks after the last transition, and never in a tick that carries a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_in | input | 1 | Raw data line from the radio, asynchronous |
| out_valid | output | 1 | Decoded byte is held on out_data |
| out_ready | input | 1 | Consumer takes the held byte at this edge |
| out_data | output | BYTE_W | Decoded byte, first received bit in bit 0 |
| frame_end | output | 1 | One-cycle pulse on the closing marker |
| chan_busy | output | 1 | Line activity seen, for carrier sense |

## Verification
Two things can land on the same clock edge: the consumer taking the held byte, and the next byte completing in the decoder. Only one correct result exists for that edge: the new byte must be loaded, not lost. To provoke it, a two-byte frame is sent with `out_ready` held low. The cycle in which `out_ready` is released is then swept across a window around the arrival of the second byte, counted from the observed rise of `out_valid`. For each offset, the bench computes from the 16 half-bit spacing between bytes whether the second byte must be delivered, and compares that with the bytes actually handed over.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  // receiver operating mode
  typedef enum logic {
    RX_HUNT,
    RX_PAYLOAD
  } rx_mode_e;

  // half-bit pair codes, first half in the upper bit
  localparam logic [1:0] PAIR_ONE  = 2'b10;
  localparam logic [1:0] PAIR_ZERO = 2'b01;
  localparam logic [1:0] PAIR_LOW  = 2'b00;
endpackage

// File: rtl/mrx_sync_edge.sv
module mrx_sync_edge #(
  parameter int CLKS_PER_SAMPLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_in,
  output logic samp_tick,
  output logic samp_lvl,
  output logic samp_edge
);
  logic [1:0] meta_q;
  logic       lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_q <= '0;
    else        meta_q <= {meta_q[0], rf_in};
  end

  generate
    if (CLKS_PER_SAMPLE == 1) begin : g_every_clk
      assign samp_tick = 1'b1;
    end else begin : g_divided
      localparam int DW = $clog2(CLKS_PER_SAMPLE);
      localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_SAMPLE - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign samp_tick = (div_q == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lvl_q <= 1'b0;
    else if (samp_tick) lvl_q <= meta_q[1];
  end

  assign samp_lvl  = meta_q[1];
  assign samp_edge = samp_tick && (meta_q[1] != lvl_q);
endmodule

// File: rtl/mrx_half_sampler.sv
module mrx_half_sampler #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic samp_lvl,
  input  logic samp_edge,
  output logic half_stb,
  output logic half_lvl
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] IDX_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] IDX_MID  = CW'(OVS / 2);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_now;

  // every transition restarts the half-bit phase at sample zero
  always_comb begin
    if (samp_edge)              idx_now = '0;
    else if (idx_q == IDX_LAST) idx_now = '0;
    else                        idx_now = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= IDX_LAST;
    else if (samp_tick) idx_q <= idx_now;
  end

  assign half_stb = samp_tick && (idx_now == IDX_MID);
  assign half_lvl = samp_lvl;
endmodule

// File: rtl/mrx_carrier.sv
module mrx_carrier #(
  parameter int WIN_SAMPLES   = 32,
  parameter int QUIET_SAMPLES = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic samp_edge,
  output logic chan_busy
);
  localparam int GW = $clog2(QUIET_SAMPLES + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(QUIET_SAMPLES);
  localparam logic [GW-1:0] GAP_WIN = GW'(WIN_SAMPLES);

  logic [GW-1:0] gap_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_SAT;
      busy_q <= 1'b0;
    end else if (samp_tick) begin
      if (samp_edge) begin
        if (gap_q < GAP_WIN) busy_q <= 1'b1;
        gap_q <= '0;
      end else if (gap_q != GAP_SAT) begin
        gap_q <= gap_q + 1'b1;
        if (gap_q == GAP_SAT - 1'b1) busy_q <= 1'b0;
      end
    end
  end

  assign chan_busy = busy_q;
endmodule

// File: rtl/mrx_framer.sv
module mrx_framer
  import mrx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_stb,
  input  logic              half_lvl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              frame_end
);
  localparam int SYNC_W = 2 * PRE_BITS + 2;
  localparam logic [SYNC_W-1:0] SYNC_WORD = {{PRE_BITS{PAIR_ONE}}, 2'b11};
  localparam int BCW = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);

  rx_mode_e          mode_q;
  logic [SYNC_W-1:0] hunt_q;
  logic              phase_q;
  logic              first_q;
  logic [BCW-1:0]    bit_cnt_q;
  logic [BYTE_W-1:0] asm_q;
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;
  logic              fend_q;

  logic [SYNC_W-1:0] hunt_next;
  logic [1:0]        pair;
  logic              pair_done;
  logic              data_pair;
  logic [BYTE_W-1:0] asm_next;
  logic              byte_done;
  logic              take;
  logic              load;

  assign hunt_next = {hunt_q[SYNC_W-2:0], half_lvl};
  assign pair      = {first_q, half_lvl};
  assign pair_done = half_stb && (mode_q == RX_PAYLOAD) && phase_q;
  assign data_pair = (pair == PAIR_ONE) || (pair == PAIR_ZERO);
  assign asm_next  = {first_q, asm_q[BYTE_W-1:1]};
  assign byte_done = pair_done && data_pair && (bit_cnt_q == BIT_LAST);
  assign take      = valid_q && out_ready;
  assign load      = byte_done && (!valid_q || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= RX_HUNT;
      hunt_q    <= '0;
      phase_q   <= 1'b0;
      first_q   <= 1'b0;
      bit_cnt_q <= '0;
      asm_q     <= '0;
      fend_q    <= 1'b0;
    end else begin
      fend_q <= 1'b0;
      if (half_stb) begin
        unique case (mode_q)
          RX_HUNT: begin
            hunt_q <= hunt_next;
            if (hunt_next == SYNC_WORD) begin
              mode_q    <= RX_PAYLOAD;
              phase_q   <= 1'b0;
              bit_cnt_q <= '0;
            end
          end
          RX_PAYLOAD: begin
            if (!phase_q) begin
              first_q <= half_lvl;
              phase_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              if (data_pair) begin
                asm_q     <= asm_next;
                bit_cnt_q <= (bit_cnt_q == BIT_LAST) ? '0 : bit_cnt_q + 1'b1;
              end else begin
                // either violation leaves the frame; only the low one closes it
                fend_q <= (pair == PAIR_LOW);
                mode_q <= RX_HUNT;
                hunt_q <= '0;
              end
            end
          end
          default: mode_q <= RX_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= asm_next;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign frame_end = fend_q;
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int BYTE_W          = 8,
  parameter int OVS             = 8,
  parameter int CLKS_PER_SAMPLE = 4,
  parameter int PRE_BITS        = 4,
  parameter int QUIET_SAMPLES   = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              frame_end,
  output logic              chan_busy
);
  localparam int WIN_SAMPLES = 4 * OVS;

  logic samp_tick;
  logic samp_lvl;
  logic samp_edge;
  logic half_stb;
  logic half_lvl;

  mrx_sync_edge #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_in     (rf_in),
    .samp_tick (samp_tick),
    .samp_lvl  (samp_lvl),
    .samp_edge (samp_edge)
  );

  mrx_half_sampler #(.OVS(OVS)) u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .samp_lvl  (samp_lvl),
    .samp_edge (samp_edge),
    .half_stb  (half_stb),
    .half_lvl  (half_lvl)
  );

  mrx_carrier #(.WIN_SAMPLES(WIN_SAMPLES), .QUIET_SAMPLES(QUIET_SAMPLES)) u_carrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .samp_edge (samp_edge),
    .chan_busy (chan_busy)
  );

  mrx_framer #(.BYTE_W(BYTE_W), .PRE_BITS(PRE_BITS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_stb  (half_stb),
    .half_lvl  (half_lvl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .frame_end (frame_end)
  );
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              frame_end,
  input logic              chan_busy,
  input logic              samp_edge
);
  // R6
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  end_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R4
  end_no_new_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !$rose(out_valid));

  // R7
  busy_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_busy) |-> $past(samp_edge));

  // R8
  busy_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_busy) |-> !$past(samp_edge));
endmodule

bind manchester_rx mrx_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .frame_end (frame_end),
  .chan_busy (chan_busy),
  .samp_edge (samp_edge)
);

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W     = 8;
  localparam int OVS        = 8;
  localparam int CPS        = 1;
  localparam int QUIET      = 64;
  localparam int HALF_CLKS  = OVS * CPS;
  localparam int BYTE_GAP   = 16 * HALF_CLKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_in = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [BYTE_W-1:0] out_data;
  logic frame_end;
  logic chan_busy;

  int n_tests = 0;
  int n_fail = 0;
  int fe_cnt = 0;
  logic [7:0] got[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  manchester_rx #(
    .BYTE_W(BYTE_W), .OVS(OVS), .CLKS_PER_SAMPLE(CPS),
    .PRE_BITS(4), .QUIET_SAMPLES(QUIET)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rf_in(rf_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .frame_end(frame_end), .chan_busy(chan_busy)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) got.push_back(out_data);
      if (frame_end) fe_cnt++;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic half(input logic v);
    rf_in = v;
    repeat (HALF_CLKS) @(negedge clk);
  endtask

  task automatic mbit(input logic b);
    half(b);
    half(!b);
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) mbit(1'b1);
  endtask

  task automatic open_mark();
    half(1'b1);
    half(1'b1);
  endtask

  task automatic close_mark();
    half(1'b0);
    half(1'b0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) mbit(b[i]);
  endtask

  task automatic idle(input int halves);
    rf_in = 1'b0;
    repeat (halves * HALF_CLKS) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int fe0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check_eq("R1 valid in reset", int'(out_valid), 0);
    check_eq("R1 frame_end in reset", int'(frame_end), 0);
    check_eq("R1 busy in reset", int'(chan_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 valid after release", int'(out_valid), 0);
    idle(10);

    // R2 every byte value in one long frame
    out_ready = 1'b1;
    got.delete();
    fe0 = fe_cnt;
    preamble(4);
    open_mark();
    check_eq("R7 busy during preamble", int'(chan_busy), 1);
    for (int v = 0; v < 256; v++) send_byte(8'(v));
    close_mark();
    idle(4);
    check_eq("R2 byte count", got.size(), 256);
    for (int v = 0; v < 256; v++)
      if (v < got.size()) check_eq("R2 byte value", int'(got[v]), v);
    check_eq("R4 one frame_end", fe_cnt - fe0, 1);
    check_eq("R8 busy held inside quiet", int'(chan_busy), 1);
    idle(6);
    check_eq("R8 busy cleared after quiet", int'(chan_busy), 0);

    // R4 lengths 0..3 with a trailing partial byte of the same bit count
    for (int len = 0; len < 4; len++) begin
      got.delete();
      fe0 = fe_cnt;
      preamble(4);
      open_mark();
      for (int k = 0; k < len; k++) send_byte(8'(8'hA5 ^ (k * 37 + len)));
      for (int p = 0; p < len; p++) mbit(1'b1);
      close_mark();
      idle(12);
      check_eq("R4 length", got.size(), len);
      for (int k = 0; k < len; k++)
        if (k < got.size()) check_eq("R4 content", int'(got[k]), int'(8'(8'hA5 ^ (k * 37 + len))));
      check_eq("R4 frame_end count", fe_cnt - fe0, 1);
    end

    // R5 high violation aborts silently, then relock
    got.delete();
    fe0 = fe_cnt;
    preamble(4);
    open_mark();
    send_byte(8'h3C);
    half(1'b1);
    half(1'b1);
    send_byte(8'h00);
    close_mark();
    idle(12);
    check_eq("R5 bytes before abort", got.size(), 1);
    if (got.size() > 0) check_eq("R5 kept byte", int'(got[0]), 8'h3C);
    check_eq("R5 no frame_end", fe_cnt - fe0, 0);
    got.delete();
    preamble(4);
    open_mark();
    send_byte(8'h81);
    close_mark();
    idle(12);
    check_eq("R5 relock count", got.size(), 1);
    if (got.size() > 0) check_eq("R5 relock byte", int'(got[0]), 8'h81);

    // R3 ones without a high marker, and too short a run of ones
    got.delete();
    fe0 = fe_cnt;
    preamble(4);
    send_byte(8'h0F);
    close_mark();
    idle(12);
    preamble(3);
    open_mark();
    send_byte(8'h00);
    close_mark();
    idle(12);
    check_eq("R3 no bytes unlocked", got.size(), 0);
    check_eq("R3 no frame_end unlocked", fe_cnt - fe0, 0);

    // R6 back-pressure for a whole frame
    got.delete();
    @(posedge clk);
    #2 out_ready = 1'b0;
    preamble(4);
    open_mark();
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'h33);
    close_mark();
    idle(4);
    check_eq("R6 held valid", int'(out_valid), 1);
    check_eq("R6 held data", int'(out_data), 8'h11);
    @(posedge clk);
    #2 out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R6 one byte delivered", got.size(), 1);
    if (got.size() > 0) check_eq("R6 delivered value", int'(got[0]), 8'h11);
    check_eq("R6 valid drops after take", int'(out_valid), 0);
    idle(12);

    // R6 sweep the ready release around the second byte's arrival
    for (int d = BYTE_GAP - 8; d < BYTE_GAP + 8; d++) begin
      got.delete();
      @(posedge clk);
      #2 out_ready = 1'b0;
      @(negedge clk);
      fork
        begin
          preamble(4);
          open_mark();
          send_byte(8'hC3);
          send_byte(8'h5A);
          close_mark();
          idle(4);
        end
        begin
          while (!out_valid) @(negedge clk);
          repeat (d) @(posedge clk);
          #2 out_ready = 1'b1;
        end
      join
      idle(8);
      check_eq("R6 sweep count", got.size(), (d + 1 <= BYTE_GAP) ? 2 : 1);
      if (got.size() > 0) check_eq("R6 sweep first", int'(got[0]), 8'hC3);
      if (got.size() > 1) check_eq("R6 sweep second", int'(got[1]), 8'h5A);
    end

    // R7 pulse width sweep across the two-bit-period window
    idle(12);
    for (int h = 4 * OVS - 4; h <= 4 * OVS + 4; h++) begin
      rf_in = 1'b1;
      repeat (h * CPS) @(negedge clk);
      rf_in = 1'b0;
      repeat (6) @(negedge clk);
      check_eq("R7 window", int'(chan_busy), (h <= 4 * OVS) ? 1 : 0);
      repeat (QUIET * CPS + 20) @(negedge clk);
    end

    // R8 exact quiet interval after the last transition
    rf_in = 1'b1;
    repeat (10) @(negedge clk);
    rf_in = 1'b0;
    repeat (QUIET * CPS - 4) @(negedge clk);
    check_eq("R8 busy before quiet expires", int'(chan_busy), 1);
    repeat (8) @(negedge clk);
    check_eq("R8 busy after quiet expires", int'(chan_busy), 0);

    summary();
    $finish;
  end
endmodule